// File: doc/BRIEF.md
# Periodic Clock Offset Corrector

This block sits between a 32.768 kHz slow-clock enable and the calendar logic, and it trims the oscillator's frequency error. It divides slow-clock pulses down to a one-second tick. Once per correction interval it stretches or shrinks one second by an even number of slow-clock pulses, so that the long-run second rate matches true time.

A single 8-bit setting controls the correction. Bit 7 picks the interval: 60 s when set, 20 s when clear. Bit 6 picks the direction: subtract when set, add when clear. Bits 5:0 hold the correction code.

A written setting is held as pending, and a busy flag rises. The pending setting becomes active at the next interval boundary, and the busy flag drops at that same boundary. The correction always lands on the first second of each interval.

At nominal parameters one step of two pulses is about 3051 ppb in the 20 s interval and about 1017 ppb in the 60 s interval. The block supports a parameterised prescaler length (which must exceed 124) and parameterised interval lengths.

Top module: `clk_trim_corrector`

## Requirements
- R1: Setting bit 7 selects the interval length. When it is 1 an interval is LONG_SECS seconds, and when it is 0 an interval is SHORT_SECS seconds. Only the first second of each interval carries a correction.
- R2: Setting bit 6 selects the direction. When it is 1 pulses are removed, and when it is 0 pulses are added.
- R3: A code (bits 5:0) of 0 or 1 applies no correction in either direction, so every second lasts PRESCALE slow ticks.
- R4: When adding with a code c of 2 or more, the first second of the interval lasts PRESCALE + 2·(c−1) slow ticks. The largest value is +124.
- R5: When subtracting with a code c of 2 or more, the code is the 6-bit two's complement of the step count. The first second lasts PRESCALE − 2·(64−c) slow ticks, which gives 2 to 124 pulses removed.
- R6: Every other second lasts exactly PRESCALE slow ticks. sec_tick is a one-cycle pulse in the clock cycle after the slow tick that ends the second.
- R7: A write raises busy in the next cycle. busy stays high until the next interval boundary. At that boundary it clears and the written setting becomes active for the interval that starts there.
- R8: A write while busy replaces the pending setting. Only the last value written before the boundary is applied.
- R9: cfg_rd returns the last value written, from the cycle after the write.
- R10: After reset no correction is active, busy is low, cfg_rd is 0 and the interval is SHORT_SECS seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_tick | input | 1 | One-cycle enable per 32.768 kHz pulse |
| cfg_we | input | 1 | Write strobe for the correction setting |
| cfg_wdata | input | 8 | Setting: [7] long interval, [6] subtract, [5:0] code |
| cfg_rd | output | 8 | Pending (last written) setting |
| busy | output | 1 | High while a written setting awaits an interval boundary |
| sec_tick | output | 1 | Corrected one-second pulse to the calendar |

## Verification
The bench builds the block with PRESCALE = 256, SHORT_SECS = 2 and LONG_SECS = 3. These values keep the full ±124-pulse range meaningful against the prescaler, and they put dozens of interval boundaries and mode switches within a short run. Slow ticks arrive with random gaps, so second lengths are measured in slow ticks rather than in cycles. Directed extremes cover codes 0, 1, 2 and 63 in both directions and both modes. Back-to-back overwrites are mixed with random settings written at random seconds.

// File: rtl/trim_pkg.sv
package trim_pkg;

  // Correction setting layout; bit positions are decoded by the datapath.
  typedef struct packed {
    logic       long_iv;  // [7] 1: long interval, 0: short interval
    logic       sub;      // [6] 1: remove pulses, 0: add pulses
    logic [5:0] code;     // [5:0] step code
  } trim_cfg_t;

  localparam int MAX_TRIM = 124;

  // Signed pulse adjustment applied to the first second of an interval.
  function automatic int trim_delta(trim_cfg_t c);
    int code;
    code = int'(c.code);
    if (code < 2) return 0;            // 0: off, 1: outside the range
    if (c.sub) return -2 * (64 - code);
    return 2 * (code - 1);
  endfunction

  // Length of a second in slow ticks.
  function automatic int second_len(int base, trim_cfg_t c, logic first);
    return first ? base + trim_delta(c) : base;
  endfunction

endpackage

// File: rtl/trim_cfg_reg.sv
module trim_cfg_reg
  import trim_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  trim_cfg_t wr_data,
  input  logic      boundary,
  output trim_cfg_t pending,
  output trim_cfg_t active,
  output logic      busy
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= '0;
      active  <= '0;
      busy    <= 1'b0;
    end else begin
      if (wr_en) pending <= wr_data;
      if (boundary) active <= pending;
      if (wr_en) busy <= 1'b1;
      else if (boundary) busy <= 1'b0;
    end
  end

  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);
  // R7
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(boundary));
  // R7
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active));
  // R8
  pend_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> pending == $past(wr_data));

endmodule

// File: rtl/trim_interval.sv
module trim_interval #(
  parameter int SHORT_SECS = 20,
  parameter int LONG_SECS  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_evt,
  input  logic long_iv,
  output logic first_sec,
  output logic boundary
);

  localparam int MAX_SECS = (LONG_SECS > SHORT_SECS) ? LONG_SECS : SHORT_SECS;
  localparam int IDX_W    = $clog2(MAX_SECS + 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_SECS - 1);
  localparam logic [IDX_W-1:0] LAST_LONG  = IDX_W'(LONG_SECS - 1);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;

  assign last_idx  = long_iv ? LAST_LONG : LAST_SHORT;
  assign first_sec = (idx == '0);
  assign boundary  = sec_evt && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n)        idx <= '0;
    else if (boundary) idx <= '0;
    else if (sec_evt)  idx <= idx + 1'b1;
  end

  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= last_idx);

endmodule

// File: rtl/trim_prescaler.sv
module trim_prescaler #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic [CNT_W-1:0] sec_len,
  output logic             sec_evt
);

  logic [CNT_W-1:0] cnt;
  logic             at_end;

  assign at_end  = (cnt == sec_len - 1'b1);
  assign sec_evt = slow_tick && at_end;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (slow_tick) cnt <= at_end ? '0 : cnt + 1'b1;
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < sec_len);

endmodule

// File: rtl/clk_trim_corrector.sv
module clk_trim_corrector
  import trim_pkg::*;
#(
  parameter int PRESCALE   = 32768,
  parameter int SHORT_SECS = 20,
  parameter int LONG_SECS  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slow_tick,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rd,
  output logic       busy,
  output logic       sec_tick
);

  localparam int CNT_W = $clog2(PRESCALE + MAX_TRIM + 1);

  trim_cfg_t        pending, active;
  logic             sec_evt, boundary, first_sec;
  logic [CNT_W-1:0] sec_len;

  assign sec_len = CNT_W'(second_len(PRESCALE, active, first_sec));
  assign cfg_rd  = pending;

  trim_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(trim_cfg_t'(cfg_wdata)),
    .boundary(boundary), .pending(pending), .active(active), .busy(busy)
  );

  trim_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sec_len(sec_len),
    .sec_evt(sec_evt)
  );

  trim_interval #(.SHORT_SECS(SHORT_SECS), .LONG_SECS(LONG_SECS)) u_iv (
    .clk(clk), .rst_n(rst_n), .sec_evt(sec_evt), .long_iv(active.long_iv),
    .first_sec(first_sec), .boundary(boundary)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) sec_tick <= 1'b0;
    else        sec_tick <= sec_evt;
  end

  // R6
  tick_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);
  // R10
  rst_state_chk: assert property (@(posedge clk)
    !rst_n |=> (!busy && !sec_tick && cfg_rd == 8'h00));

endmodule

// File: tb/sim_clk_trim_corrector.sv
`timescale 1ns/1ps
module sim_clk_trim_corrector;
  localparam int P = 256, SS = 2, LS = 3;

  logic clk = 1'b0, rst_n = 1'b0, slow_tick = 1'b0, cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  wire [7:0] cfg_rd;
  wire busy, sec_tick;

  clk_trim_corrector #(.PRESCALE(P), .SHORT_SECS(SS), .LONG_SECS(LS)) u0 (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .busy(busy), .sec_tick(sec_tick));

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0, slow_cnt = 0, m_idx = 0;
  logic [7:0] m_act = 8'h00, m_pend = 8'h00;
  bit m_busy = 0, m_ovr = 0, act_ovr = 0, timed_out = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_delta(logic [7:0] c);
    int code = int'(c[5:0]);
    if (code < 2) return 0;
    if (c[6]) return -2 * ((((~code) & 63)) + 1);
    return 2 * (code - 1);
  endfunction

  function automatic int n_secs(logic [7:0] c);
    return c[7] ? LS : SS;
  endfunction

  function automatic string tag_of(int idx, logic [7:0] c, bit ovr);
    string t;
    if (idx != 0) t = "R6";
    else if (c[5:0] < 2) t = "R3 R1";
    else if (c[6]) t = "R2 R5 R1";
    else t = "R2 R4 R1";
    if (ovr && idx == 0) t = {t, " R8"};
    return t;
  endfunction

  task automatic step();
    @(negedge clk);
    cyc++;
    cfg_we = 1'b0;
    slow_cnt += int'(slow_tick);
    slow_tick = (($urandom % 4) != 0);
  endtask

  task automatic process_tick();
    int per = 0, exp;
    bit got = 0;
    while (!got && !timed_out) begin
      step();
      if (sec_tick) begin per = slow_cnt; slow_cnt = 0; got = 1; end
      if (cyc > 190000) timed_out = 1;
    end
    if (!got) return;
    exp = (m_idx == 0) ? P + exp_delta(m_act) : P;
    chk(per == exp, tag_of(m_idx, m_act, act_ovr), per, exp);
    if (m_idx == n_secs(m_act) - 1) begin
      m_idx = 0; m_act = m_pend; m_busy = 0; act_ovr = m_ovr; m_ovr = 0;
    end else m_idx++;
    chk(busy == m_busy, "R7", int'(busy), int'(m_busy));
  endtask

  task automatic write_cfg(logic [7:0] v);
    if (m_busy) m_ovr = 1;
    cfg_we = 1'b1; cfg_wdata = v; m_pend = v; m_busy = 1;
    @(negedge clk);
    cyc++;
    cfg_we = 1'b0;
    slow_cnt += int'(slow_tick);
    slow_tick = (($urandom % 4) != 0);
    chk(busy == 1'b1, "R7", int'(busy), 1);
    chk(cfg_rd == v, "R9", int'(cfg_rd), int'(v));
  endtask

  initial begin
    logic [7:0] dir [8];
    void'($urandom(32'd2024));
    dir = '{8'h02, 8'hBF, 8'h42, 8'hFF, 8'h40, 8'h41, 8'h01, 8'h80};
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10", int'(busy), 0);
    chk(cfg_rd == 8'h00, "R10", int'(cfg_rd), 0);
    chk(sec_tick == 1'b0, "R10", int'(sec_tick), 0);
    rst_n = 1'b1;
    slow_cnt = 0;
    // Power-up interval: short, no correction.
    for (int i = 0; i < SS + 1; i++) process_tick();
    // Directed extremes, each given time to land and be measured.
    for (int k = 0; k < 8; k++) begin
      write_cfg(dir[k]);
      for (int i = 0; i < 4; i++) process_tick();
    end
    // Overwrite while busy: only the second value applies.
    write_cfg(8'h85);
    write_cfg(8'h7E);
    for (int i = 0; i < 4; i++) process_tick();
    // Random settings at random seconds.
    for (int i = 0; i < 110 && !timed_out; i++) begin
      if (($urandom % 4) == 0) write_cfg(8'($urandom));
      process_tick();
    end
    if (timed_out) chk(1'b0, "watchdog", cyc, 190000);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule